// File: doc/BRIEF.md
# UART control and status register bank

This block is the software-visible register front end of a UART. A host reaches it over a simple bus carrying a byte address, an access-size code, write and read enables, 16-bit write data and 16-bit read data. It holds the baud divisor halves, global, line and modem control, a scratch word, the interrupt enable word, the line status word and the modem status word. It also holds the last byte queued for transmission. The serial engine beside it takes the configuration from dedicated outputs. It receives a one-cycle strobe whenever a byte is queued or a received byte is consumed, and it reports error and change conditions through event inputs that stick in the status words until software clears them.

The interrupt enable word has no direct write path. Software ORs bits in through one alias address and removes them through another, and both aliases read back the same word. Error bits in the line status word and the CTS-change bit in the modem status word are cleared by writing ones. Any access of the wrong size, at a misaligned or unmapped address, or with read and write asserted together is refused and flagged.

Top module: `uart_regbank`

## Requirements
- R1: The twelve registers sit at byte offsets 0x00 (divisor low), 0x04 (divisor high), 0x08 (global control), 0x0C (line control), 0x10 (modem control), 0x14 (line status), 0x18 (modem status), 0x1C (scratch), 0x20 (enable-set alias), 0x24 (enable-clear alias), 0x28 (transmit holding), 0x2C (receive buffer).
- R2: An access with size code other than 2'b01 (16-bit), an address not a multiple of 4 or above 0x2C, or read and write enables high together changes no register, reads 0, raises no strobe, and pulses bus_err for one cycle on the next clock.
- R3: Divisor low, divisor high, global control, line control, modem control and scratch store all 16 written bits and read them back; the first five also drive the outputs div_lo, div_hi, gctl_o, lcr_o and mcr_o.
- R4: After reset, divisor low reads 0x0001, line status reads 0x0060 (with no live status), and every other register and strobe is 0.
- R5: A write to the enable-set alias ORs the write data into the enable word (ier_o) on the next clock.
- R6: A write to the enable-clear alias clears each enable bit whose write-data bit is 1; a read of either alias returns the enable word.
- R7: A line-status write clears stored bits 1, 2, 3, 4 and 7 where the data bit is 1 (mask 0x009E); all other line-status bits ignore writes.
- R8: A line-status read returns the stored word ORed with live_stat, and the live bits are folded into the stored word at that clock.
- R9: Each bit set in lsr_evt sets the same line-status bit at the next clock, winning over a write-one-to-clear in the same cycle.
- R10: Modem-status bit 0 (CTS changed) is set by cts_chg and cleared by writing 1 to it, the set winning; all other modem-status bits read 0 and ignore writes.
- R11: A transmit-holding write latches the data on tx_data and pulses tx_load for one cycle on the next clock; tx_irq pulses with it only if enable bit 1 was set; a read returns the latched value.
- R12: A receive-buffer read returns {8'h00, rx_byte} and pulses rx_pop for one cycle on the next clock; a receive-buffer write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_size | input | 2 | Access size code, 2'b01 is the only legal (16-bit) |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |
| bus_err | output | 1 | One-cycle pulse after a refused access |
| rx_byte | input | LINE_W | Received byte from the serial engine |
| live_stat | input | LINE_W | Live line condition bits, aligned to line status |
| lsr_evt | input | LINE_W | Sticky line events, aligned to line status |
| cts_chg | input | 1 | CTS change event |
| div_lo | output | 16 | Divisor low word |
| div_hi | output | 16 | Divisor high word |
| gctl_o | output | 16 | Global control |
| lcr_o | output | 16 | Line control |
| mcr_o | output | 16 | Modem control |
| ier_o | output | 16 | Interrupt enable word |
| tx_data | output | 16 | Latched transmit holding value |
| tx_load | output | 1 | Transmit-load strobe |
| tx_irq | output | 1 | Transmit-empty interrupt event |
| rx_pop | output | 1 | Receive-pop strobe |

## Verification
On every cycle the assertions check the enable alias arithmetic, the strobe that follows each holding-register write or receive-buffer read, the error pulse after a refused access, that tx_irq never fires without tx_load, and that a line or CTS event is present in its status bit one clock later. The bench's scenarios are needed to show the read-data values across the map, the reset contents, write-one-to-clear masking against the bits that must hold, the folding of live status at a line-status read, and that refused or read-only writes leave every register unchanged when read back.

// File: rtl/uart_regbank_pkg.sv
`timescale 1ns/1ps
package uart_regbank_pkg;

    localparam int REG_W     = 16;
    localparam int NUM_SLOTS = 12;
    localparam int NUM_PLAIN = 6;

    // word slot numbers; byte offset is slot * 4
    localparam int SLOT_DIVLO = 0;
    localparam int SLOT_DIVHI = 1;
    localparam int SLOT_GCTL  = 2;
    localparam int SLOT_LCTL  = 3;
    localparam int SLOT_MCTL  = 4;
    localparam int SLOT_LSTAT = 5;
    localparam int SLOT_MSTAT = 6;
    localparam int SLOT_SCR   = 7;
    localparam int SLOT_IESET = 8;
    localparam int SLOT_IECLR = 9;
    localparam int SLOT_THOLD = 10;
    localparam int SLOT_RBUF  = 11;

    localparam logic [1:0] SIZE_HALF = 2'b01;

    // line status bit positions
    localparam int LS_OVR    = 1;
    localparam int LS_PAR    = 2;
    localparam int LS_FRM    = 3;
    localparam int LS_BRK    = 4;
    localparam int LS_TXDONE = 7;
    // modem status and enable bit positions
    localparam int MS_CTSCHG = 0;
    localparam int IE_TXEMPTY = 1;

    localparam logic [REG_W-1:0] LS_W1C_MASK =
        REG_W'((1 << LS_OVR) | (1 << LS_PAR) | (1 << LS_FRM) |
               (1 << LS_BRK) | (1 << LS_TXDONE));
    localparam logic [REG_W-1:0] LS_INIT    = 16'h0060;
    localparam logic [REG_W-1:0] DIVLO_INIT = 16'h0001;

    // slot number of each plain read/write register, in storage order
    function automatic int plain_slot(input int k);
        case (k)
            0:       return SLOT_DIVLO;
            1:       return SLOT_DIVHI;
            2:       return SLOT_GCTL;
            3:       return SLOT_LCTL;
            4:       return SLOT_MCTL;
            default: return SLOT_SCR;
        endcase
    endfunction

    typedef struct packed {
        logic                 wr;
        logic                 rd;
        logic                 err;
        logic [NUM_SLOTS-1:0] sel;
    } bus_acc_t;

endpackage

// File: rtl/uart_rb_decode.sv
`timescale 1ns/1ps
module uart_rb_decode
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic              rd,
    output bus_acc_t          acc
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]     idx;
    logic [NUM_SLOTS-1:0] hit;
    logic                 any_req;
    logic                 legal;

    assign idx = addr[ADDR_W-1:2];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            assign hit[g] = (idx == IDX_W'(g));
        end
    endgenerate

    assign any_req = wr | rd;
    assign legal   = (addr[1:0] == 2'b00) && (size == SIZE_HALF) &&
                     !(wr && rd) && (hit != '0);

    always_comb begin
        acc.wr  = any_req && legal && wr;
        acc.rd  = any_req && legal && rd;
        acc.err = any_req && !legal;
        acc.sel = (any_req && legal) ? hit : '0;
    end
endmodule

// File: rtl/uart_rb_ier.sv
`timescale 1ns/1ps
module uart_rb_ier
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ier
);
    logic [REG_W-1:0] ier_d;
    logic [REG_W-1:0] ier_q;

    always_comb begin
        ier_d = ier_q;
        if (set_en) ier_d = ier_d | wdata;
        if (clr_en) ier_d = ier_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ier_q <= '0;
        else        ier_q <= ier_d;
    end

    assign ier = ier_q;
endmodule

// File: rtl/uart_rb_status.sv
`timescale 1ns/1ps
module uart_rb_status
    import uart_regbank_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ls_rd,
    input  logic              ls_wr,
    input  logic              ms_wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [LINE_W-1:0] live,
    input  logic [LINE_W-1:0] evt,
    input  logic              cts_evt,
    output logic [REG_W-1:0]  ls_val,
    output logic [REG_W-1:0]  ms_val
);
    typedef struct packed {
        logic [REG_W-1:0] ls;
        logic             cts;
    } stat_t;

    stat_t s_d;
    stat_t s_q;

    always_comb begin
        s_d = s_q;
        // fold live condition on a read, then clear, then sticky set
        if (ls_rd) s_d.ls = s_d.ls | REG_W'(live);
        if (ls_wr) s_d.ls = s_d.ls & ~(wdata & LS_W1C_MASK);
        s_d.ls = s_d.ls | REG_W'(evt);
        if (ms_wr && wdata[MS_CTSCHG]) s_d.cts = 1'b0;
        if (cts_evt)                   s_d.cts = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ls  <= LS_INIT;
            s_q.cts <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ls_val = s_q.ls;
    always_comb begin
        ms_val            = '0;
        ms_val[MS_CTSCHG] = s_q.cts;
    end
endmodule

// File: rtl/uart_regbank.sv
`timescale 1ns/1ps
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [LINE_W-1:0] rx_byte,
    input  logic [LINE_W-1:0] live_stat,
    input  logic [LINE_W-1:0] lsr_evt,
    input  logic              cts_chg,
    output logic [REG_W-1:0]  div_lo,
    output logic [REG_W-1:0]  div_hi,
    output logic [REG_W-1:0]  gctl_o,
    output logic [REG_W-1:0]  lcr_o,
    output logic [REG_W-1:0]  mcr_o,
    output logic [REG_W-1:0]  ier_o,
    output logic [REG_W-1:0]  tx_data,
    output logic              tx_load,
    output logic              tx_irq,
    output logic              rx_pop
);
    typedef struct packed {
        logic [NUM_PLAIN-1:0][REG_W-1:0] plain;
        logic [REG_W-1:0]                thold;
        logic                            load;
        logic                            irq;
        logic                            pop;
        logic                            err;
    } bank_t;

    bus_acc_t         acc;
    bank_t            b_d;
    bank_t            b_q;
    logic [REG_W-1:0] ier_val;
    logic [REG_W-1:0] lsr_val;
    logic [REG_W-1:0] msr_val;

    uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc)
    );

    uart_rb_ier u_ier (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (acc.wr && acc.sel[SLOT_IESET]),
        .clr_en (acc.wr && acc.sel[SLOT_IECLR]),
        .wdata  (bus_wdata),
        .ier    (ier_val)
    );

    uart_rb_status #(.LINE_W(LINE_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ls_rd   (acc.rd && acc.sel[SLOT_LSTAT]),
        .ls_wr   (acc.wr && acc.sel[SLOT_LSTAT]),
        .ms_wr   (acc.wr && acc.sel[SLOT_MSTAT]),
        .wdata   (bus_wdata),
        .live    (live_stat),
        .evt     (lsr_evt),
        .cts_evt (cts_chg),
        .ls_val  (lsr_val),
        .ms_val  (msr_val)
    );

    always_comb begin
        b_d = b_q;
        for (int k = 0; k < NUM_PLAIN; k++) begin
            if (acc.wr && acc.sel[plain_slot(k)]) b_d.plain[k] = bus_wdata;
        end
        b_d.load = acc.wr && acc.sel[SLOT_THOLD];
        b_d.irq  = b_d.load && ier_val[IE_TXEMPTY];
        if (b_d.load) b_d.thold = bus_wdata;
        b_d.pop  = acc.rd && acc.sel[SLOT_RBUF];
        b_d.err  = acc.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q          <= '0;
            b_q.plain[0] <= DIVLO_INIT;
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            for (int k = 0; k < NUM_PLAIN; k++) begin
                if (acc.sel[plain_slot(k)]) bus_rdata = b_q.plain[k];
            end
            if (acc.sel[SLOT_LSTAT]) bus_rdata = lsr_val | REG_W'(live_stat);
            if (acc.sel[SLOT_MSTAT]) bus_rdata = msr_val;
            if (acc.sel[SLOT_IESET] || acc.sel[SLOT_IECLR]) bus_rdata = ier_val;
            if (acc.sel[SLOT_THOLD]) bus_rdata = b_q.thold;
            if (acc.sel[SLOT_RBUF])  bus_rdata = REG_W'(rx_byte);
        end
    end

    assign div_lo  = b_q.plain[0];
    assign div_hi  = b_q.plain[1];
    assign gctl_o  = b_q.plain[2];
    assign lcr_o   = b_q.plain[3];
    assign mcr_o   = b_q.plain[4];
    assign ier_o   = ier_val;
    assign tx_data = b_q.thold;
    assign tx_load = b_q.load;
    assign tx_irq  = b_q.irq;
    assign rx_pop  = b_q.pop;
    assign bus_err = b_q.err;
endmodule

// File: rtl/uart_regbank_chk.sv
`timescale 1ns/1ps
module uart_regbank_chk
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_err,
    input logic [LINE_W-1:0] lsr_evt,
    input logic              cts_chg,
    input logic [REG_W-1:0]  ier_o,
    input logic [REG_W-1:0]  tx_data,
    input logic              tx_load,
    input logic              tx_irq,
    input logic              rx_pop,
    input logic [REG_W-1:0]  lsr_val,
    input logic [REG_W-1:0]  msr_val
);
    localparam logic [ADDR_W-1:0] A_IESET = ADDR_W'(SLOT_IESET * 4);
    localparam logic [ADDR_W-1:0] A_IECLR = ADDR_W'(SLOT_IECLR * 4);
    localparam logic [ADDR_W-1:0] A_THOLD = ADDR_W'(SLOT_THOLD * 4);
    localparam logic [ADDR_W-1:0] A_RBUF  = ADDR_W'(SLOT_RBUF * 4);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'((NUM_SLOTS - 1) * 4);

    logic ok;
    assign ok = (bus_size == SIZE_HALF) && (bus_addr[1:0] == 2'b00) &&
                (bus_addr <= A_LAST) && (bus_wr != bus_rd);

    a_r5_ier_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && bus_wr && bus_addr == A_IESET) |=>
        ier_o == ($past(ier_o) | $past(bus_wdata)));

    a_r6_ier_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && bus_wr && bus_addr == A_IECLR) |=>
        ier_o == ($past(ier_o) & ~$past(bus_wdata)));

    a_r11_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && bus_wr && bus_addr == A_THOLD) |=>
        (tx_load && tx_data == $past(bus_wdata)));

    a_r11_irq_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_load);

    a_r12_rx_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && bus_rd && bus_addr == A_RBUF) |=> rx_pop);

    a_r2_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !ok) |=> (bus_err && !tx_load && !rx_pop));

    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_evt != '0) |=>
        ((lsr_val & REG_W'($past(lsr_evt))) == REG_W'($past(lsr_evt))));

    a_r10_cts_set: assert property (@(posedge clk) disable iff (!rst_n)
        cts_chg |=> msr_val[MS_CTSCHG]);
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .lsr_evt   (lsr_evt),
    .cts_chg   (cts_chg),
    .ier_o     (ier_o),
    .tx_data   (tx_data),
    .tx_load   (tx_load),
    .tx_irq    (tx_irq),
    .rx_pop    (rx_pop),
    .lsr_val   (lsr_val),
    .msr_val   (msr_val)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  rx_byte = '0;
    logic [7:0]  live_stat = '0;
    logic [7:0]  lsr_evt = '0;
    logic        cts_chg = 1'b0;
    logic [15:0] div_lo, div_hi, gctl_o, lcr_o, mcr_o, ier_o, tx_data;
    logic        tx_load, tx_irq, rx_pop;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_plain [12];
    logic [15:0] m_ier, m_lsr, m_msr, m_thr;

    always #10 clk = ~clk;

    uart_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_byte(rx_byte),
        .live_stat(live_stat), .lsr_evt(lsr_evt), .cts_chg(cts_chg),
        .div_lo(div_lo), .div_hi(div_hi), .gctl_o(gctl_o), .lcr_o(lcr_o),
        .mcr_o(mcr_o), .ier_o(ier_o), .tx_data(tx_data), .tx_load(tx_load),
        .tx_irq(tx_irq), .rx_pop(rx_pop)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_legal(bit w, bit r, logic [7:0] a, logic [1:0] sz);
        return (w || r) && !(w && r) && a[1:0] == 2'b00 && sz == 2'b01 && a <= 8'h2C;
    endfunction

    function automatic string req_for(bit legal, int sl, bit w);
        if (!legal) return "R2";
        case (sl)
            5:       return w ? "R7" : "R8";
            6:       return "R10";
            8:       return "R5";
            9:       return "R6";
            10:      return "R11";
            11:      return "R12";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [15:0] model_read(int sl, logic [7:0] live, logic [7:0] rxb);
        case (sl)
            5:       return m_lsr | {8'h00, live};
            6:       return m_msr;
            8, 9:    return m_ier;
            10:      return m_thr;
            11:      return {8'h00, rxb};
            default: return m_plain[sl];
        endcase
    endfunction

    task automatic do_acc(input bit w, input bit r, input logic [7:0] a,
                          input logic [1:0] sz, input logic [15:0] wd,
                          input logic [7:0] ev, input bit cts,
                          input logic [7:0] live, input logic [7:0] rxb,
                          input string tag);
        bit legal;
        int sl;
        string t;
        logic [15:0] exp_rd;
        logic [3:0] exp_strb;
        legal = is_legal(w, r, a, sz);
        sl = int'(a >> 2);
        t = (tag == "") ? req_for(legal, sl, w) : tag;
        exp_rd = (legal && r) ? model_read(sl, live, rxb) : 16'h0000;
        exp_strb[3] = legal && w && sl == 10;
        exp_strb[2] = exp_strb[3] && m_ier[1];
        exp_strb[1] = legal && r && sl == 11;
        exp_strb[0] = (w || r) && !legal;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_size = sz; bus_wdata = wd;
        lsr_evt = ev; cts_chg = cts; live_stat = live; rx_byte = rxb;
        #5;
        if (r) chk(t, "read data", bus_rdata, exp_rd);
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; lsr_evt = '0; cts_chg = 1'b0; live_stat = '0;
        chk(t, "strobes {load,irq,pop,err}", {12'h0, tx_load, tx_irq, rx_pop, bus_err},
            {12'h0, exp_strb});
        if (legal && w) begin
            case (sl)
                5:  m_lsr = m_lsr & ~(wd & 16'h009E);
                6:  if (wd[0]) m_msr[0] = 1'b0;
                8:  m_ier = m_ier | wd;
                9:  m_ier = m_ier & ~wd;
                10: m_thr = wd;
                11: ;
                default: m_plain[sl] = wd;
            endcase
        end
        if (legal && r && sl == 5) m_lsr = m_lsr | {8'h00, live};
        m_lsr = m_lsr | {8'h00, ev};
        if (cts) m_msr[0] = 1'b1;
    endtask

    task automatic rd(input int sl, input string tag);
        do_acc(1'b0, 1'b1, 8'(sl * 4), 2'b01, 16'h0, 8'h0, 1'b0, 8'h0, 8'h5A, tag);
    endtask

    task automatic wr(input int sl, input logic [15:0] d, input string tag);
        do_acc(1'b1, 1'b0, 8'(sl * 4), 2'b01, d, 8'h0, 1'b0, 8'h0, 8'h0, tag);
    endtask

    task automatic chk_ports(input string tag);
        #1;
        chk(tag, "div_lo", div_lo, m_plain[0]);
        chk(tag, "div_hi", div_hi, m_plain[1]);
        chk(tag, "gctl_o", gctl_o, m_plain[2]);
        chk(tag, "lcr_o", lcr_o, m_plain[3]);
        chk(tag, "mcr_o", mcr_o, m_plain[4]);
        chk(tag, "ier_o", ier_o, m_ier);
        chk(tag, "tx_data", tx_data, m_thr);
    endtask

    initial begin
        #4ms;
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 12; i++) m_plain[i] = 16'h0;
        m_plain[0] = 16'h0001;
        m_ier = '0; m_lsr = 16'h0060; m_msr = '0; m_thr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R4: reset contents on ports and through the map
        chk_ports("R4");
        chk("R4", "strobes after reset", {12'h0, tx_load, tx_irq, rx_pop, bus_err}, 16'h0);
        for (int s = 0; s < 12; s++) rd(s, "R4");

        // R1 R3: plain registers, distinct patterns per slot
        wr(0, 16'hA5C3, "R3"); wr(1, 16'h0F0F, "R3"); wr(2, 16'h8001, "R3");
        wr(3, 16'h00FF, "R3"); wr(4, 16'hFF00, "R3"); wr(7, 16'h1234, "R1");
        for (int s = 0; s < 8; s++) if (s != 5 && s != 6) rd(s, "R1");
        chk_ports("R3");

        // R5 R6: enable aliases
        wr(8, 16'h0003, "R5"); wr(8, 16'h0104, "R5"); rd(8, "R5"); rd(9, "R6");
        wr(9, 16'h0101, "R6"); rd(8, "R6"); chk_ports("R6");

        // R11: holding write with transmit-empty enable set, then cleared
        wr(10, 16'h00C7, "R11"); rd(10, "R11");
        wr(9, 16'h0002, "R11");
        wr(10, 16'h0042, "R11"); chk_ports("R11");

        // R12: receive buffer read pops; write ignored
        do_acc(1'b0, 1'b1, 8'h2C, 2'b01, 16'h0, 8'h0, 1'b0, 8'h0, 8'h9C, "R12");
        do_acc(1'b1, 1'b0, 8'h2C, 2'b01, 16'hFFFF, 8'h0, 1'b0, 8'h0, 8'h00, "R12");
        do_acc(1'b0, 1'b1, 8'h2C, 2'b01, 16'h0, 8'h0, 1'b0, 8'h0, 8'h3E, "R12");
        chk_ports("R12");

        // R7 R9: events, W1C, set wins over clear
        do_acc(1'b0, 1'b0, 8'h00, 2'b01, 16'h0, 8'h9E, 1'b0, 8'h0, 8'h0, "R9");
        rd(5, "R9");
        wr(5, 16'h0008, "R7"); rd(5, "R7");
        do_acc(1'b1, 1'b0, 8'h14, 2'b01, 16'hFFFF, 8'h04, 1'b0, 8'h0, 8'h0, "R9");
        rd(5, "R9");
        wr(5, 16'hFFFF, "R7"); rd(5, "R7");

        // R8: live status folded at read
        do_acc(1'b0, 1'b1, 8'h14, 2'b01, 16'h0, 8'h0, 1'b0, 8'h01, 8'h0, "R8");
        rd(5, "R8");

        // R10: CTS change
        do_acc(1'b0, 1'b0, 8'h00, 2'b01, 16'h0, 8'h0, 1'b1, 8'h0, 8'h0, "R10");
        rd(6, "R10");
        wr(6, 16'hFFFE, "R10"); rd(6, "R10");
        do_acc(1'b1, 1'b0, 8'h18, 2'b01, 16'hFFFF, 8'h0, 1'b1, 8'h0, 8'h0, "R10");
        rd(6, "R10");
        wr(6, 16'h0001, "R10"); rd(6, "R10");

        // R2: refused accesses leave state unchanged
        do_acc(1'b1, 1'b0, 8'h00, 2'b10, 16'hDEAD, 8'h0, 1'b0, 8'h0, 8'h0, "R2");
        do_acc(1'b1, 1'b0, 8'h02, 2'b01, 16'hBEEF, 8'h0, 1'b0, 8'h0, 8'h0, "R2");
        do_acc(1'b1, 1'b0, 8'h30, 2'b01, 16'hBEEF, 8'h0, 1'b0, 8'h0, 8'h0, "R2");
        do_acc(1'b1, 1'b1, 8'h28, 2'b01, 16'h7777, 8'h0, 1'b0, 8'h0, 8'h0, "R2");
        do_acc(1'b0, 1'b1, 8'h2C, 2'b00, 16'h0, 8'h0, 1'b0, 8'h0, 8'h11, "R2");
        do_acc(1'b1, 1'b0, 8'h20, 2'b11, 16'hFFFF, 8'h0, 1'b0, 8'h0, 8'h0, "R2");
        rd(0, "R2"); rd(8, "R2"); chk_ports("R2");

        // random mix
        for (int i = 0; i < 2500; i++) begin
            logic [7:0] a;
            logic [1:0] sz;
            bit w, r;
            int op;
            op = int'($urandom_range(0, 19));
            w = (op < 9) || (op == 19);
            r = (op >= 9);
            a = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 63))
                                            : 8'($urandom_range(0, 11) * 4);
            sz = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b01;
            do_acc(w, r, a, sz, 16'($urandom),
                   ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0,
                   ($urandom_range(0, 7) == 0),
                   ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0,
                   8'($urandom), "");
        end
        chk_ports("R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule